// File: doc/BRIEF.md
# Instruction Fetch Address Translator

This block turns the virtual address of an instruction fetch into a physical address. For each fetch it reports one of three fault codes: none, access violation or miss. A request takes one of three routes. The first is a physical-mode bypass that passes the address through unchanged. The second is a kernel-only superpage window that maps a fixed region of the virtual space straight onto physical memory. The third is a lookup in a small fully-associative table. That table is tagged by virtual page number and address-space number, and each entry carries a per-mode read/execute permission mask.

A request is presented for one cycle with `req_valid`. The registered result appears on the next cycle with `rsp_valid`, together with a one-cycle event pulse for a good table hit, a table miss or an access violation. Software or a refill engine loads table entries through a plain indexed write port. Page-table walking is left to whatever consumes the miss code.

Pages are 8 KB, so the offset is VA[12:0] and the page number is VA[42:13]. The implemented virtual space is 43 bits, sign-extended to 64, and the physical address is 40 bits wide. The mode encoding is kernel=0, executive=1, supervisor=2 and user=3.

Top module: `itlb_xlate`

## Requirements
- R1: A result is registered: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and low in every other cycle.
- R2: With `req_phys` set, `rsp_pa` equals VA[39:0] and `rsp_fault` is 0 (none), with no validity, window or permission check, and no event pulse.
- R3: Otherwise, a VA whose bits 63:42 are not all equal is invalid and gives `rsp_fault`=1 (access violation) with `ev_acv`, before any other check.
- R4: A valid VA with `sp_en[1]` set and VA[42:41]=2'b10 takes the superpage route. In kernel mode this route gives fault 0 and `rsp_pa` = VA[39:0], low bits included, and no hit pulse. With `sp_en[1]` clear, the same address goes to the table.
- R5: A superpage access in any mode other than kernel (0) gives fault 1 and `ev_acv`.
- R6: Otherwise the table is searched for a valid entry whose page number equals VA[42:13] and whose ASN equals `cur_asn`. If no entry matches, the result is fault 2 (miss) with `ev_miss`.
- R7: On a permitted hit, `rsp_pa` = {entry frame, VA[12:2], 2'b00} and the fault is 0.
- R8: A hit whose permission mask has bit `cur_mode` clear gives fault 1 and `ev_acv`.
- R9: `ev_hit` pulses only for a permitted table hit. At most one of the three event pulses is high at a time, and only together with `rsp_valid`.
- R10: When several entries match, the one with the lowest index supplies the frame and the permission mask.
- R11: A table write in the same cycle as a request is not seen by that request. It is seen by the next request.
- R12: Reset clears every entry's valid bit and drives `rsp_valid` and all event pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Translation request strobe |
| req_va | input | 64 | Fetch virtual address |
| req_phys | input | 1 | Physical-mode bypass |
| cur_mode | input | 2 | Current mode (0 kernel .. 3 user) |
| sp_en | input | 2 | Superpage enable; bit 1 enables the window |
| cur_asn | input | ASN_W | Current address-space number |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | $clog2(ENTRIES) | Entry index to write |
| wr_vpn | input | VA_IMPL-13 | Page number tag |
| wr_asn | input | ASN_W | ASN tag |
| wr_pfn | input | PA_W-13 | Physical frame number |
| wr_xre | input | 4 | Read/execute enable, one bit per mode |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | PA_W | Physical address (0 on fault) |
| rsp_fault | output | 2 | 0 none, 1 access violation, 2 miss |
| ev_hit | output | 1 | Permitted table hit pulse |
| ev_miss | output | 1 | Table miss pulse |
| ev_acv | output | 1 | Access violation pulse |

## Verification
Table insertion and table lookup can happen in the same cycle, and so can an insertion into an entry that is being matched at that moment. The bench drives a write of a new page and a request for that page on the same clock edge. It expects a miss for that request and a hit, with the new frame, for the following request. It also overwrites a matching duplicate and checks that lowest-index priority picks the correct frame afterwards.

// File: rtl/itlb_xlate.sv
module itlb_xlate #(
  parameter int ENTRIES = 8,
  parameter int ASN_W   = 8,
  parameter int PA_W    = 40,
  parameter int VA_W    = 64,
  parameter int VA_IMPL = 43,
  parameter int PG_SH   = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [VA_W-1:0]            req_va,
  input  logic                       req_phys,
  input  logic [1:0]                 cur_mode,
  input  logic [1:0]                 sp_en,
  input  logic [ASN_W-1:0]           cur_asn,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic [VA_IMPL-PG_SH-1:0]   wr_vpn,
  input  logic [ASN_W-1:0]           wr_asn,
  input  logic [PA_W-PG_SH-1:0]      wr_pfn,
  input  logic [3:0]                 wr_xre,
  output logic                       rsp_valid,
  output logic [PA_W-1:0]            rsp_pa,
  output logic [1:0]                 rsp_fault,
  output logic                       ev_hit,
  output logic                       ev_miss,
  output logic                       ev_acv
);
  localparam int VPN_W = VA_IMPL - PG_SH;
  localparam int PFN_W = PA_W - PG_SH;
  localparam logic [1:0] F_NONE = 2'd0;
  localparam logic [1:0] F_ACV  = 2'd1;
  localparam logic [1:0] F_MISS = 2'd2;

  logic [ENTRIES-1:0] ent_v;
  logic [VPN_W-1:0]   ent_vpn [ENTRIES];
  logic [ASN_W-1:0]   ent_asn [ENTRIES];
  logic [PFN_W-1:0]   ent_pfn [ENTRIES];
  logic [3:0]         ent_xre [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) ent_v <= '0;
    else if (wr_en) ent_v[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_vpn[wr_idx] <= wr_vpn;
      ent_asn[wr_idx] <= wr_asn;
      ent_pfn[wr_idx] <= wr_pfn;
      ent_xre[wr_idx] <= wr_xre;
    end
  end

  logic [VPN_W-1:0]   va_vpn;
  logic [ENTRIES-1:0] match;
  assign va_vpn = req_va[VA_IMPL-1:PG_SH];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_v[g] && ent_vpn[g] == va_vpn && ent_asn[g] == cur_asn;
  end

  logic             hit;
  logic [PFN_W-1:0] sel_pfn;
  logic [3:0]       sel_xre;

  always_comb begin
    hit = 1'b0;
    sel_pfn = '0;
    sel_xre = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit = 1'b1;
        sel_pfn = ent_pfn[i];
        sel_xre = ent_xre[i];
      end
    end
  end

  logic va_ok, in_window, allowed;
  assign va_ok     = (&req_va[VA_W-1:VA_IMPL-1]) | ~(|req_va[VA_W-1:VA_IMPL-1]);
  assign in_window = sp_en[1] && req_va[VA_IMPL-1:VA_IMPL-2] == 2'b10;
  assign allowed   = sel_xre[cur_mode];

  logic            unused_ok;
  assign unused_ok = sp_en[0];

  logic [1:0]      nx_fault;
  logic [PA_W-1:0] nx_pa;
  logic            nx_hit;

  always_comb begin
    nx_fault = F_NONE;
    nx_pa = '0;
    nx_hit = 1'b0;
    if (req_phys) nx_pa = req_va[PA_W-1:0];
    else if (!va_ok) nx_fault = F_ACV;
    else if (in_window) begin
      if (cur_mode != 2'd0) nx_fault = F_ACV;
      else nx_pa = req_va[PA_W-1:0];
    end
    else if (!hit) nx_fault = F_MISS;
    else if (!allowed) nx_fault = F_ACV;
    else begin
      nx_pa = {sel_pfn, req_va[PG_SH-1:2], 2'b00};
      nx_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_pa    <= '0;
      rsp_fault <= F_NONE;
      ev_hit    <= 1'b0;
      ev_miss   <= 1'b0;
      ev_acv    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      ev_hit    <= req_valid && nx_hit;
      ev_miss   <= req_valid && nx_fault == F_MISS;
      ev_acv    <= req_valid && nx_fault == F_ACV;
      if (req_valid) begin
        rsp_pa    <= nx_pa;
        rsp_fault <= nx_fault;
      end
    end
  end
endmodule

module itlb_xlate_chk #(
  parameter int PA_W = 40,
  parameter int VA_W = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic [VA_W-1:0] req_va,
  input logic            req_phys,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_pa,
  input logic [1:0]      rsp_fault,
  input logic            ev_hit,
  input logic            ev_miss,
  input logic            ev_acv
);
  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  a_r2_bypass_passes: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_phys |=> rsp_fault == 2'd0 && rsp_pa == $past(req_va[PA_W-1:0]) && !ev_acv && !ev_miss && !ev_hit);
  a_r6_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |-> rsp_valid && rsp_fault == 2'd2);
  a_r7_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> rsp_pa[1:0] == 2'b00);
  a_r9_events_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_hit, ev_miss, ev_acv}));
  a_r9_hit_clean: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hit |-> rsp_valid && rsp_fault == 2'd0);
  a_r9_acv_code: assert property (@(posedge clk) disable iff (!rst_n)
    ev_acv |-> rsp_valid && rsp_fault == 2'd1);
endmodule

bind itlb_xlate itlb_xlate_chk #(.PA_W(PA_W), .VA_W(VA_W)) i_chk (.*);

// File: tb/test_itlb_xlate.sv
module test_itlb_xlate;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_phys, wr_en;
  logic [63:0] req_va;
  logic [1:0]  cur_mode, sp_en;
  logic [7:0]  cur_asn, wr_asn;
  logic [2:0]  wr_idx;
  logic [29:0] wr_vpn;
  logic [26:0] wr_pfn;
  logic [3:0]  wr_xre;
  logic        rsp_valid, ev_hit, ev_miss, ev_acv;
  logic [39:0] rsp_pa;
  logic [1:0]  rsp_fault;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  itlb_xlate i_itlb_xlate (.*);

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_va(logic [29:0] vpn, logic [12:0] off);
    return {21'b0, vpn, off};
  endfunction

  task automatic fetch(logic [63:0] va, logic phys, logic [1:0] mode, logic [1:0] sp, logic [7:0] asn);
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_phys = phys;
    cur_mode = mode; sp_en = sp; cur_asn = asn;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic put(logic [2:0] idx, logic [29:0] vpn, logic [7:0] asn, logic [26:0] pfn, logic [3:0] xre);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_asn = asn; wr_pfn = pfn; wr_xre = xre;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_rsp(string req, logic [39:0] pa, logic [1:0] f, logic h, logic m, logic a);
    check(req, "rsp_valid", 64'(rsp_valid), 64'd1);
    check(req, "rsp_fault", 64'(rsp_fault), 64'(f));
    if (f == 2'd0) check(req, "rsp_pa", 64'(rsp_pa), 64'(pa));
    check(req, "events", 64'({ev_hit, ev_miss, ev_acv}), 64'({h, m, a}));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    check("R12", "rsp_valid", 64'(rsp_valid), 64'd0);
    check("R12", "events", 64'({ev_hit, ev_miss, ev_acv}), 64'd0);
    @(negedge clk);
    check("R1", "idle rsp_valid", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_bypass();
    fetch(64'h0000_0800_1234_5677, 1'b1, 2'd3, 2'b10, 8'd0);
    expect_rsp("R2", 40'h00_1234_5677, 2'd0, 0, 0, 0);
    @(negedge clk);
    check("R1", "single rsp", 64'(rsp_valid), 64'd0);
  endtask

  task automatic t_invalid();
    fetch(64'h0000_0800_0000_1000, 1'b0, 2'd0, 2'b10, 8'd0);
    expect_rsp("R3", 40'd0, 2'd1, 0, 0, 1);
    fetch(64'h8000_0000_0000_1000, 1'b0, 2'd0, 2'b00, 8'd0);
    expect_rsp("R3", 40'd0, 2'd1, 0, 0, 1);
  endtask

  task automatic t_superpage();
    logic [63:0] va = 64'hFFFF_FC12_3456_7ABF;
    fetch(va, 1'b0, 2'd0, 2'b10, 8'd0);
    expect_rsp("R4", va[39:0], 2'd0, 0, 0, 0);
    fetch(va, 1'b0, 2'd3, 2'b10, 8'd0);
    expect_rsp("R5", 40'd0, 2'd1, 0, 0, 1);
    fetch(va, 1'b0, 2'd1, 2'b10, 8'd0);
    expect_rsp("R5", 40'd0, 2'd1, 0, 0, 1);
    fetch(va, 1'b0, 2'd0, 2'b01, 8'd0);
    expect_rsp("R4", 40'd0, 2'd2, 0, 1, 0);
  endtask

  task automatic t_lookup();
    logic [29:0] vpn = 30'h0012_3456;
    put(3'd0, vpn, 8'd5, 27'h2AB_CDEF, 4'b0001);
    fetch(mk_va(vpn, 13'h1ABF), 1'b0, 2'd0, 2'b10, 8'd5);
    expect_rsp("R7", {27'h2AB_CDEF, 13'h1ABC}, 2'd0, 1, 0, 0);
    fetch(mk_va(vpn, 13'h0003), 1'b0, 2'd0, 2'b10, 8'd6);
    expect_rsp("R6", 40'd0, 2'd2, 0, 1, 0);
    fetch(mk_va(vpn + 30'd1, 13'h0), 1'b0, 2'd0, 2'b10, 8'd5);
    expect_rsp("R6", 40'd0, 2'd2, 0, 1, 0);
    fetch(mk_va(vpn, 13'h0010), 1'b0, 2'd3, 2'b10, 8'd5);
    expect_rsp("R8", 40'd0, 2'd1, 0, 0, 1);
    put(3'd4, 30'h0000_0777, 8'd5, 27'h000_0042, 4'b1000);
    fetch(mk_va(30'h0000_0777, 13'h0FFE), 1'b0, 2'd3, 2'b10, 8'd5);
    expect_rsp("R9", {27'h000_0042, 13'h0FFC}, 2'd0, 1, 0, 0);
    fetch(mk_va(30'h0000_0777, 13'h0FFE), 1'b0, 2'd2, 2'b10, 8'd5);
    expect_rsp("R8", 40'd0, 2'd1, 0, 0, 1);
  endtask

  task automatic t_priority();
    logic [29:0] vpn = 30'h0001_0101;
    put(3'd3, vpn, 8'd9, 27'h000_3333, 4'b1111);
    put(3'd1, vpn, 8'd9, 27'h000_1111, 4'b0001);
    fetch(mk_va(vpn, 13'h0100), 1'b0, 2'd0, 2'b10, 8'd9);
    expect_rsp("R10", {27'h000_1111, 13'h0100}, 2'd0, 1, 0, 0);
    fetch(mk_va(vpn, 13'h0100), 1'b0, 2'd3, 2'b10, 8'd9);
    expect_rsp("R10", 40'd0, 2'd1, 0, 0, 1);
  endtask

  task automatic t_collide();
    logic [29:0] vpn = 30'h0002_0202;
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'd2; wr_vpn = vpn; wr_asn = 8'd7;
    wr_pfn = 27'h000_5555; wr_xre = 4'b0001;
    req_valid = 1'b1; req_va = mk_va(vpn, 13'h0008); req_phys = 1'b0;
    cur_mode = 2'd0; sp_en = 2'b10; cur_asn = 8'd7;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    expect_rsp("R11", 40'd0, 2'd2, 0, 1, 0);
    fetch(mk_va(vpn, 13'h0008), 1'b0, 2'd0, 2'b10, 8'd7);
    expect_rsp("R11", {27'h000_5555, 13'h0008}, 2'd0, 1, 0, 0);
    put(3'd1, vpn, 8'd7, 27'h000_6666, 4'b0001);
    fetch(mk_va(vpn, 13'h0008), 1'b0, 2'd0, 2'b10, 8'd7);
    expect_rsp("R10", {27'h000_6666, 13'h0008}, 2'd0, 1, 0, 0);
  endtask

  task automatic t_reset_clears();
    do_reset();
    fetch(mk_va(30'h0012_3456, 13'h0), 1'b0, 2'd0, 2'b10, 8'd5);
    expect_rsp("R12", 40'd0, 2'd2, 0, 1, 0);
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0; req_phys = 1'b0;
    cur_mode = 2'd0; sp_en = 2'b00; cur_asn = '0;
    wr_en = 1'b0; wr_idx = '0; wr_vpn = '0; wr_asn = '0; wr_pfn = '0; wr_xre = '0;
    t_reset();
    t_bypass();
    t_invalid();
    t_superpage();
    t_lookup();
    t_priority();
    t_collide();
    t_reset_clears();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule